// File: doc/BRIEF.md
# Sixteen-bit Rotating ALU

This block is the purely combinational arithmetic and logic unit of a small 16-bit core. It takes two 16-bit operands, a primary value A (normally the destination or first source register) and a second-source value B, plus a 4-bit operation select. In the same cycle it returns a 16-bit result and three condition flags: negative, zero and carry.

The operation set is deliberately narrow. It has subtraction, an unsigned greater-than test that returns 0 or 1, and a packing of the two operands' top nibbles into one byte. There are also pass-through, clear, increment and decrement. Logical shifts and rotations in both directions take their amount from the low four bits of B. The enclosing core owns the register file, memory, decoding and the flag register that latches the outputs. This unit holds no state.

There is no clock and no state register. The single selection point is a case over the operation select, and each named code picks one output path.

Top module: `alu16_core`

## Requirements
- R1: Select code 0 (SUB) gives `result` = (A - B) modulo 2^16.
- R2: Select code 1 (GT) gives `result` = 1 when A > B, compared unsigned, and 0 otherwise. All other result bits are 0.
- R3: Select code 2 (CAT) gives `result[7:4]` = A[15:12] and `result[3:0]` = B[15:12], with `result[15:8]` = 0.
- R4: Select code 3 (MOV) gives `result` = A, and select code 4 (CLR) gives `result` = 0.
- R5: Select code 5 (INC) gives (A + 1) modulo 2^16, and select code 6 (DEC) gives (A - 1) modulo 2^16.
- R6: Select code 7 (SHL) shifts A left and select code 8 (SHR) shifts A right, both filling with zeros. The shift amount is B[3:0], and B[15:4] has no effect on the shift.
- R7: Select code 9 (ROL) rotates A left and select code 10 (ROR) rotates A right, by B[3:0] places. An amount of 0 returns A unchanged.
- R8: `flag_n` equals `result[15]`, and `flag_z` is 1 exactly when `result` is all zeros, for every select code.
- R9: `flag_c` is the borrow out for SUB (1 when A < B unsigned) and for DEC (1 when A = 0). It is the carry out for INC (1 when A = 0xFFFF).
- R10: For SHL and SHR, `flag_c` is the last bit shifted out: A[16-n] for SHL and A[n-1] for SHR, where n = B[3:0]. When n is 0, `flag_c` is 0.
- R11: `flag_c` is 0 for GT, CAT, MOV, CLR, ROL and ROR. Select codes 11 to 15 are unused and give `result` = 0 with `flag_c` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation select code |
| opnd_a | input | 16 | Primary operand A (destination / first source value) |
| opnd_b | input | 16 | Second-source operand B; low 4 bits are the shift/rotate amount |
| result | output | 16 | Operation result |
| flag_n | output | 1 | Negative flag (result sign bit) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow / shifted-out bit |

## Verification
The bench sweeps every select code, including the five unused ones. For each code it pairs a set of A values with all sixteen shift amounts, each under varied upper B bits, and with B equal to A. The A values include 0, 0xFFFF, 0x8000, 0x7FFF and alternating patterns. Shift amount 0 matters for both directions: a shifter that takes the carry from a wrapped index would report a stray carry, and a rotator that computes the complement amount wrongly would return zero instead of A. Equal operands expose a compare that uses greater-or-equal, or a borrow that is set on equality. INC from 0xFFFF and DEC from 0 catch a carry that is dropped or inverted. Varied B[15:4] during shifts catches a design that decodes more than four amount bits and clears the result.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int ALU_W = 16;
    localparam int SEL_W = 4;
    localparam int NIB_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_SUB = 4'd0,
        OP_GT  = 4'd1,
        OP_CAT = 4'd2,
        OP_MOV = 4'd3,
        OP_CLR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10
    } alu_op_e;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sub_res,
    output logic         sub_bo,
    output logic [W-1:0] inc_res,
    output logic         inc_co,
    output logic [W-1:0] dec_res,
    output logic         dec_bo,
    output logic [W-1:0] gt_res
);

    logic [W:0] diff_w;
    logic [W:0] inc_w;
    logic [W:0] dec_w;

    always_comb begin
        diff_w = {1'b0, a} - {1'b0, b};
        inc_w  = {1'b0, a} + (W+1)'(1);
        dec_w  = {1'b0, a} - (W+1)'(1);
    end

    assign sub_res = diff_w[W-1:0];
    assign sub_bo  = diff_w[W];
    assign inc_res = inc_w[W-1:0];
    assign inc_co  = inc_w[W];
    assign dec_res = dec_w[W-1:0];
    assign dec_bo  = dec_w[W];
    assign gt_res  = {{(W-1){1'b0}}, (a > b)};

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  shl_res,
    output logic          shl_co,
    output logic [W-1:0]  shr_res,
    output logic          shr_co,
    output logic [W-1:0]  rol_res,
    output logic [W-1:0]  ror_res
);

    // Left shift carries one extra bit above the MSB; right shift one below the LSB.
    logic [W:0]   sl_st [AW+1];
    logic [W:0]   sr_st [AW+1];
    logic [W-1:0] rl_st [AW+1];
    logic [W-1:0] rr_st [AW+1];

    assign sl_st[0] = {1'b0, a};
    assign sr_st[0] = {a, 1'b0};
    assign rl_st[0] = a;
    assign rr_st[0] = a;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int S = 2 ** k;
        assign sl_st[k+1] = amt[k] ? {sl_st[k][W-S:0], {S{1'b0}}} : sl_st[k];
        assign sr_st[k+1] = amt[k] ? {{S{1'b0}}, sr_st[k][W:S]}   : sr_st[k];
        assign rl_st[k+1] = amt[k] ? {rl_st[k][W-1-S:0], rl_st[k][W-1:W-S]} : rl_st[k];
        assign rr_st[k+1] = amt[k] ? {rr_st[k][S-1:0], rr_st[k][W-1:S]}     : rr_st[k];
    end

    assign shl_res = sl_st[AW][W-1:0];
    assign shl_co  = sl_st[AW][W];
    assign shr_res = sr_st[AW][W:1];
    assign shr_co  = sr_st[AW][0];
    assign rol_res = rl_st[AW];
    assign ror_res = rr_st[AW];

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    output logic         neg,
    output logic         zero
);

    assign neg  = res[W-1];
    assign zero = ~|res;

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W   = ALU_W,
    parameter int NIB = NIB_W
) (
    input  logic [SEL_W-1:0] op_sel,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [W-1:0]     result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c
);

    localparam int AW = $clog2(W);

    logic [W-1:0] sub_res, inc_res, dec_res, gt_res;
    logic         sub_bo, inc_co, dec_bo;
    logic [W-1:0] shl_res, shr_res, rol_res, ror_res;
    logic         shl_co, shr_co;
    logic [W-1:0] cat_res;

    alu16_arith #(.W(W)) u_arith (
        .a       (opnd_a),
        .b       (opnd_b),
        .sub_res (sub_res),
        .sub_bo  (sub_bo),
        .inc_res (inc_res),
        .inc_co  (inc_co),
        .dec_res (dec_res),
        .dec_bo  (dec_bo),
        .gt_res  (gt_res)
    );

    alu16_shift #(.W(W), .AW(AW)) u_shift (
        .a       (opnd_a),
        .amt     (opnd_b[AW-1:0]),
        .shl_res (shl_res),
        .shl_co  (shl_co),
        .shr_res (shr_res),
        .shr_co  (shr_co),
        .rol_res (rol_res),
        .ror_res (ror_res)
    );

    assign cat_res = {{(W-2*NIB){1'b0}}, opnd_a[W-1:W-NIB], opnd_b[W-1:W-NIB]};

    always_comb begin
        result = '0;
        flag_c = 1'b0;
        unique case (alu_op_e'(op_sel))
            OP_SUB: begin result = sub_res; flag_c = sub_bo; end
            OP_GT:  result = gt_res;
            OP_CAT: result = cat_res;
            OP_MOV: result = opnd_a;
            OP_CLR: result = '0;
            OP_INC: begin result = inc_res; flag_c = inc_co; end
            OP_DEC: begin result = dec_res; flag_c = dec_bo; end
            OP_SHL: begin result = shl_res; flag_c = shl_co; end
            OP_SHR: begin result = shr_res; flag_c = shr_co; end
            OP_ROL: result = rol_res;
            OP_ROR: result = ror_res;
            default: begin result = '0; flag_c = 1'b0; end
        endcase
    end

    alu16_flags #(.W(W)) u_flags (
        .res  (result),
        .neg  (flag_n),
        .zero (flag_z)
    );

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
    parameter int W = 16
) (
    input logic [3:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c
);

    logic known;
    assign known = !$isunknown({op_sel, opnd_a, opnd_b});

    always_comb begin
        if (known) begin
            // R8
            flags_nz_chk: assert (flag_n == result[W-1] && flag_z == (result == '0));
            // R4
            clr_zero_chk: assert (op_sel != 4'd4 || (result == '0 && !flag_c));
            // R2
            gt_bool_chk: assert (op_sel != 4'd1 || result == {{(W-1){1'b0}}, (opnd_a > opnd_b)});
            // R7
            rot_bits_chk: assert (!(op_sel == 4'd9 || op_sel == 4'd10) ||
                                  ($countones(result) == $countones(opnd_a) && !flag_c));
            // R10
            shift_zero_amt_chk: assert (!((op_sel == 4'd7 || op_sel == 4'd8) && opnd_b[3:0] == 4'd0) ||
                                        (result == opnd_a && !flag_c));
            // R9
            sub_borrow_chk: assert (op_sel != 4'd0 || flag_c == (opnd_a < opnd_b));
            // R11
            unused_code_chk: assert (op_sel < 4'd11 || (result == '0 && !flag_c));
        end
    end

endmodule

bind alu16_core alu16_core_chk #(.W(W)) u_chk (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c)
);

// File: tb/alu16_core_bench.sv
`timescale 1ns/100ps
module alu16_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [15:0] result;
    logic        flag_n, flag_z, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    alu16_core u_alu16_core (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .result (result),
        .flag_n (flag_n),
        .flag_z (flag_z),
        .flag_c (flag_c)
    );

    always #10 clk = ~clk;

    function automatic string res_tag(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5, 6: return "R5";
            7, 8: return "R6";
            9, 10: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic string c_tag(input int op);
        case (op)
            0, 5, 6: return "R9";
            7, 8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input int op, input longint a, input longint b,
                         output longint r, output longint c);
        longint n = b % 16;
        longint p = 64'd1 << n;
        longint q = 64'd1 << (16 - n);
        r = 0; c = 0;
        case (op)
            0: begin r = (a - b + 65536) % 65536; c = (a < b) ? 1 : 0; end
            1: r = (a > b) ? 1 : 0;
            2: r = (a / 4096) * 16 + (b / 4096);
            3: r = a;
            4: r = 0;
            5: begin r = (a + 1) % 65536; c = (a == 65535) ? 1 : 0; end
            6: begin r = (a + 65535) % 65536; c = (a == 0) ? 1 : 0; end
            7: begin r = (a * p) % 65536; c = (n == 0) ? 0 : (a / q) % 2; end
            8: begin r = a / p; c = (n == 0) ? 0 : (a / (p / 2)) % 2; end
            9: r = ((a * p) % 65536) + (a / q);
            10: r = (a / p) + ((a * q) % 65536);
            default: begin r = 0; c = 0; end
        endcase
    endtask

    task automatic apply_and_check(input int op, input logic [15:0] a, input logic [15:0] b);
        longint er, ec;
        op_sel = op[3:0];
        opnd_a = a;
        opnd_b = b;
        #1;
        model(op, longint'(a), longint'(b), er, ec);
        checks++;
        if (result !== er[15:0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
                     res_tag(op), op, a, b, result, er[15:0]);
        end
        checks++;
        if (flag_n !== er[15] || flag_z !== (er[15:0] == 16'd0)) begin
            fails++;
            $display("FAIL R8 op=%0d a=%h b=%h nz actual=%b%b expected=%b%b",
                     op, a, b, flag_n, flag_z, er[15], (er[15:0] == 16'd0));
        end
        checks++;
        if (flag_c !== ec[0]) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h carry actual=%b expected=%b",
                     c_tag(op), op, a, b, flag_c, ec[0]);
        end
        #1;
    endtask

    initial begin : watchdog
        for (int cyc = 0; cyc < 200000; cyc++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] avals [32];
        logic [15:0] lfsr;
        avals[0] = 16'h0000; avals[1] = 16'h0001; avals[2] = 16'h7FFF; avals[3] = 16'h8000;
        avals[4] = 16'hFFFF; avals[5] = 16'hF000; avals[6] = 16'h000F; avals[7] = 16'h5555;
        avals[8] = 16'hAAAA; avals[9] = 16'h8001; avals[10] = 16'h1234; avals[11] = 16'hFFFE;
        lfsr = 16'hACE1;
        for (int i = 12; i < 32; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            avals[i] = lfsr;
        end

        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2.5;

        // Reset/idle state: SUB of zeros -> result 0, Z set (R1, R8)
        apply_and_check(0, 16'h0000, 16'h0000);

        // Full sweep: every select code, every A, all B[3:0] under varied B[15:4], plus B == A
        for (int op = 0; op < 16; op++) begin
            for (int ai = 0; ai < 32; ai++) begin
                for (int bi = 0; bi <= 256; bi++) begin
                    logic [15:0] bv;
                    logic [7:0]  bb;
                    bb = bi[7:0];
                    if (bi == 256) bv = avals[ai];
                    else bv = {bb, bb[7:4] ^ 4'h9, bb[3:0]};
                    apply_and_check(op, avals[ai], bv);
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule